// File: doc/BRIEF.md
# Ethernet DMA control and status register file

This block is the software-visible register bank of an Ethernet DMA engine. A simple 32-bit bus addresses it by word index, which is the byte address shifted right by two. The bank holds the following registers:

- a bus-mode register
- the two descriptor ring bases
- the two current-descriptor pointers
- a control register
- an interrupt enable mask
- a status register

Reads are combinational on the index. A write takes effect at the clock edge on which `csr_wr` is high.

The transmit and receive engines report events as single-cycle set vectors. These are merged into the status register, and software clears status bits by writing ones to them. A single level interrupt is raised while any enabled status bit is set. A write to the transmit poll index stores nothing. It only produces a one-cycle poll pulse for the transmit engine. Two control bits are brought out directly as the receive enable and the transmit start.

Top module: `edma_csr`

## Requirements
- R1: The word indices are as follows: 0x3C0 bus mode, 0x3C3 receive ring base, 0x3C4 transmit ring base, 0x3C5 status, 0x3C6 control, 0x3C7 interrupt enable, 0x3D2 current transmit descriptor and 0x3D3 current receive descriptor. Data written in one cycle is returned by a combinational read of the same index from the following cycle on.
- R2: A write to index 0x3C5 clears every status bit that is 1 in the write data and leaves the others unchanged.
- R3: Bits of `tx_evt_set` and `rx_evt_set` are ORed into status at the clock edge. When a set and a clear hit the same bit in one cycle, the bit ends up set.
- R4: A write to a ring base also loads the same value into the matching current-descriptor pointer: receive 0x3C3 loads 0x3D3, and transmit 0x3C4 loads 0x3D2. The pointers can also be written directly, and they are visible on `cur_rx_desc` and `cur_tx_desc`.
- R5: A write to bus mode stores the data with bit 0 forced to 0.
- R6: A read of index 8 always returns 0x1012, and writes to index 8 have no effect.
- R7: A write to index 0x3C1 drives `tx_poll` high for exactly the next cycle. It stores nothing, so index 0x3C1 reads as 0.
- R8: `dma_irq` is high whenever (status AND interrupt enable) is non-zero. It follows register changes in the same cycle as they occur.
- R9: `rx_enable` equals control bit 1 and `tx_start` equals control bit 13.
- R10: Reads of unimplemented indices return 0. Writes to them change no register.
- R11: After a synchronous active-low reset, every register reads 0 and `dma_irq` and `tx_poll` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_wr | input | 1 | Write strobe |
| csr_idx | input | 10 | Word index for read and write |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data for `csr_idx` |
| tx_evt_set | input | 32 | Status set pulses from the transmit engine |
| rx_evt_set | input | 32 | Status set pulses from the receive engine |
| dma_irq | output | 1 | Level interrupt |
| tx_poll | output | 1 | One-cycle transmit poll pulse |
| rx_enable | output | 1 | Receive enable (control bit 1) |
| tx_start | output | 1 | Transmit start (control bit 13) |
| cur_tx_desc | output | 32 | Current transmit descriptor pointer |
| cur_rx_desc | output | 32 | Current receive descriptor pointer |

## Verification
The bench targets four corner cases:

- **Collision of an engine set with a software clear.** A design that lets the clear win would silently drop a receive event.
- **Ring base writes.** A design that does not reload the current pointer would leave the engine walking a stale ring.
- **Reads of the bus-mode, version and poll indices.** A design that stores the reset bit, the version write or the poll write would return the written data instead of 0 or 0x1012.
- **Unimplemented indices, with writes interleaved among engine pulses.** These catch any alias that corrupts a real register, and an interrupt that lags or ignores the enable mask.

// File: rtl/edma_csr_pkg.sv
// Shared constants and types of the DMA register file.
// Assumes a word-indexed bus; indices are plain integers cast at use.
package edma_csr_pkg;
    localparam int IDX_VERSION = 'h008;
    localparam int IDX_BUSMODE = 'h3C0;
    localparam int IDX_POLL    = 'h3C1;
    localparam int IDX_RXBASE  = 'h3C3;
    localparam int IDX_TXBASE  = 'h3C4;
    localparam int IDX_STAT    = 'h3C5;
    localparam int IDX_CTL     = 'h3C6;
    localparam int IDX_ENA     = 'h3C7;
    localparam int IDX_CURTX   = 'h3D2;
    localparam int IDX_CURRX   = 'h3D3;
    localparam int VERSION_VAL = 'h1012;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_VERSION, SEL_BUSMODE, SEL_POLL, SEL_RXBASE, SEL_TXBASE,
        SEL_STAT, SEL_CTL, SEL_ENA, SEL_CURTX, SEL_CURRX
    } csr_sel_e;
endpackage

// File: rtl/edma_csr_dec.sv
// Index decoder: maps a word index to a register selector.
// Assumes ADDR_W is wide enough to hold every index in the package.
module edma_csr_dec
    import edma_csr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] idx,
    output csr_sel_e          sel
);
    // Compare the index against each implemented location.
    always_comb begin
        case (idx)
            ADDR_W'(IDX_VERSION): sel = SEL_VERSION;
            ADDR_W'(IDX_BUSMODE): sel = SEL_BUSMODE;
            ADDR_W'(IDX_POLL):    sel = SEL_POLL;
            ADDR_W'(IDX_RXBASE):  sel = SEL_RXBASE;
            ADDR_W'(IDX_TXBASE):  sel = SEL_TXBASE;
            ADDR_W'(IDX_STAT):    sel = SEL_STAT;
            ADDR_W'(IDX_CTL):     sel = SEL_CTL;
            ADDR_W'(IDX_ENA):     sel = SEL_ENA;
            ADDR_W'(IDX_CURTX):   sel = SEL_CURTX;
            ADDR_W'(IDX_CURRX):   sel = SEL_CURRX;
            default:              sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/edma_csr_reg.sv
// Plain loadable register with a fixed write mask.
// Masked-off bits always hold 0; synchronous active-low reset.
module edma_csr_reg #(
    parameter int                DATA_W = 32,
    parameter logic [DATA_W-1:0] WMASK  = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    // Load masked data when selected.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (ld) q <= d & WMASK;
    end
endmodule

// File: rtl/edma_csr_stat.sv
// Status register: write-one-to-clear from the bus, OR-in from two engines.
// A set and a clear on the same bit in one cycle leave the bit set.
module edma_csr_stat #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_en,
    input  logic [DATA_W-1:0] clr_mask,
    input  logic [DATA_W-1:0] set_a,
    input  logic [DATA_W-1:0] set_b,
    output logic [DATA_W-1:0] stat
);
    logic [DATA_W-1:0] clr_bits;

    // Clear mask applies only on a status write.
    always_comb clr_bits = clr_en ? clr_mask : '0;

    // Clear first, then merge engine sets so sets win.
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= (stat & ~clr_bits) | set_a | set_b;
    end
endmodule

// File: rtl/edma_csr.sv
// DMA control/status register file top.
// Holds the bus-mode, ring base, current pointer, control, enable and
// status registers; reads are combinational, writes take effect at the edge.
// Assumes RXEN_BIT and TXST_BIT are below DATA_W.
module edma_csr
    import edma_csr_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 32,
    parameter int RXEN_BIT = 1,
    parameter int TXST_BIT = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr,
    input  logic [ADDR_W-1:0] csr_idx,
    input  logic [DATA_W-1:0] csr_wdata,
    output logic [DATA_W-1:0] csr_rdata,
    input  logic [DATA_W-1:0] tx_evt_set,
    input  logic [DATA_W-1:0] rx_evt_set,
    output logic              dma_irq,
    output logic              tx_poll,
    output logic              rx_enable,
    output logic              tx_start,
    output logic [DATA_W-1:0] cur_tx_desc,
    output logic [DATA_W-1:0] cur_rx_desc
);
    localparam logic [DATA_W-1:0] BUSMODE_MASK = ~(DATA_W'(1));
    localparam int NCH = 2; // channel 0 receive, 1 transmit

    csr_sel_e          sel;
    logic [DATA_W-1:0] busmode_q, ctl_q, ena_q, stat_q;
    logic [DATA_W-1:0] base_q [NCH];
    logic [DATA_W-1:0] cur_q  [NCH];

    edma_csr_dec #(.ADDR_W(ADDR_W)) u_dec (.idx(csr_idx), .sel(sel));

    edma_csr_reg #(.DATA_W(DATA_W), .WMASK(BUSMODE_MASK)) u_busmode (
        .clk(clk), .rst_n(rst_n), .ld(csr_wr && sel == SEL_BUSMODE),
        .d(csr_wdata), .q(busmode_q));
    edma_csr_reg #(.DATA_W(DATA_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .ld(csr_wr && sel == SEL_CTL),
        .d(csr_wdata), .q(ctl_q));
    edma_csr_reg #(.DATA_W(DATA_W)) u_ena (
        .clk(clk), .rst_n(rst_n), .ld(csr_wr && sel == SEL_ENA),
        .d(csr_wdata), .q(ena_q));

    // Ring base and current pointer pairs, one per direction.
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ring
        localparam csr_sel_e BASE_SEL = (ch == 0) ? SEL_RXBASE : SEL_TXBASE;
        localparam csr_sel_e CUR_SEL  = (ch == 0) ? SEL_CURRX  : SEL_CURTX;
        edma_csr_reg #(.DATA_W(DATA_W)) u_base (
            .clk(clk), .rst_n(rst_n), .ld(csr_wr && sel == BASE_SEL),
            .d(csr_wdata), .q(base_q[ch]));
        edma_csr_reg #(.DATA_W(DATA_W)) u_cur (
            .clk(clk), .rst_n(rst_n),
            .ld(csr_wr && (sel == BASE_SEL || sel == CUR_SEL)),
            .d(csr_wdata), .q(cur_q[ch]));
    end

    edma_csr_stat #(.DATA_W(DATA_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .clr_en(csr_wr && sel == SEL_STAT),
        .clr_mask(csr_wdata), .set_a(tx_evt_set), .set_b(rx_evt_set),
        .stat(stat_q));

    // One-cycle poll pulse after a poll-demand write.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_poll <= 1'b0;
        else        tx_poll <= csr_wr && sel == SEL_POLL;
    end

    // Read multiplexer; unimplemented and poll indices read zero.
    always_comb begin
        case (sel)
            SEL_VERSION: csr_rdata = DATA_W'(VERSION_VAL);
            SEL_BUSMODE: csr_rdata = busmode_q;
            SEL_RXBASE:  csr_rdata = base_q[0];
            SEL_TXBASE:  csr_rdata = base_q[1];
            SEL_STAT:    csr_rdata = stat_q;
            SEL_CTL:     csr_rdata = ctl_q;
            SEL_ENA:     csr_rdata = ena_q;
            SEL_CURRX:   csr_rdata = cur_q[0];
            SEL_CURTX:   csr_rdata = cur_q[1];
            default:     csr_rdata = '0;
        endcase
    end

    // Outputs derived from held state.
    always_comb begin
        dma_irq     = |(stat_q & ena_q);
        rx_enable   = ctl_q[RXEN_BIT];
        tx_start    = ctl_q[TXST_BIT];
        cur_rx_desc = cur_q[0];
        cur_tx_desc = cur_q[1];
    end
endmodule

// File: rtl/edma_csr_chk.sv
// Checker for edma_csr, attached by bind; observes ports and the status state.
module edma_csr_chk
    import edma_csr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              csr_wr,
    input logic [ADDR_W-1:0] csr_idx,
    input logic [DATA_W-1:0] csr_wdata,
    input logic [DATA_W-1:0] csr_rdata,
    input logic [DATA_W-1:0] tx_evt_set,
    input logic [DATA_W-1:0] rx_evt_set,
    input logic              dma_irq,
    input logic              tx_poll,
    input logic [DATA_W-1:0] cur_rx_desc,
    input logic [DATA_W-1:0] stat_q
);
    AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && csr_idx == ADDR_W'(IDX_STAT) && tx_evt_set == '0 && rx_evt_set == '0)
        |=> stat_q == ($past(stat_q) & ~$past(csr_wdata))); // R2
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_evt_set | rx_evt_set) != '0)
        |=> (stat_q & $past(tx_evt_set | rx_evt_set)) == $past(tx_evt_set | rx_evt_set)); // R3
    AST_RX_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && csr_idx == ADDR_W'(IDX_RXBASE)) |=> cur_rx_desc == $past(csr_wdata)); // R4
    AST_BUSMODE_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_idx == ADDR_W'(IDX_BUSMODE)) |-> !csr_rdata[0]); // R5
    AST_VERSION_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_idx == ADDR_W'(IDX_VERSION)) |-> csr_rdata == DATA_W'(VERSION_VAL)); // R6
    AST_POLL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_poll == $past(csr_wr && csr_idx == ADDR_W'(IDX_POLL))); // R7
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        dma_irq |-> stat_q != '0); // R8
endmodule

bind edma_csr edma_csr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_idx(csr_idx),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .tx_evt_set(tx_evt_set),
    .rx_evt_set(rx_evt_set), .dma_irq(dma_irq), .tx_poll(tx_poll),
    .cur_rx_desc(cur_rx_desc), .stat_q(stat_q));

// File: tb/edma_csr_bench.sv
// Bench for edma_csr: behavioural reference model compared every cycle.
module edma_csr_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr = 1'b0;
    logic [9:0]  csr_idx = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic [31:0] tx_evt_set = '0;
    logic [31:0] rx_evt_set = '0;
    logic        dma_irq, tx_poll, rx_enable, tx_start;
    logic [31:0] cur_tx_desc, cur_rx_desc;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit chk_on = 1'b0;
    string rd_tag = "R1";

    // Reference state.
    logic [31:0] m_bus, m_rxb, m_txb, m_stat, m_ctl, m_ena, m_ctx, m_crx;
    bit m_poll;

    edma_csr u_edma_csr (.*);

    always #10 clk = ~clk; // 50 MHz

    function automatic logic [31:0] m_read(input int idx);
        case (idx)
            'h008: return 32'h1012;
            'h3C0: return m_bus;
            'h3C3: return m_rxb;
            'h3C4: return m_txb;
            'h3C5: return m_stat;
            'h3C6: return m_ctl;
            'h3C7: return m_ena;
            'h3D2: return m_ctx;
            'h3D3: return m_crx;
            default: return 32'h0;
        endcase
    endfunction

    // Reference model update at each edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            {m_bus, m_rxb, m_txb, m_stat, m_ctl, m_ena, m_ctx, m_crx} = '0;
            m_poll = 0;
        end else begin
            m_poll = csr_wr && csr_idx == 10'h3C1;
            m_stat = (m_stat & ~((csr_wr && csr_idx == 10'h3C5) ? csr_wdata : 32'h0))
                     | tx_evt_set | rx_evt_set;
            if (csr_wr) begin
                case (int'(csr_idx))
                    'h3C0: m_bus = csr_wdata & 32'hFFFF_FFFE;
                    'h3C3: begin m_rxb = csr_wdata; m_crx = csr_wdata; end
                    'h3C4: begin m_txb = csr_wdata; m_ctx = csr_wdata; end
                    'h3C6: m_ctl = csr_wdata;
                    'h3C7: m_ena = csr_wdata;
                    'h3D2: m_ctx = csr_wdata;
                    'h3D3: m_crx = csr_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Compare outputs away from the active edge.
    always @(negedge clk) begin
        if (chk_on) begin
            check(rd_tag, csr_rdata, m_read(int'(csr_idx)));
            check("R8 irq", 32'(dma_irq), 32'(|(m_stat & m_ena)));
            check("R7 poll", 32'(tx_poll), 32'(m_poll));
            check("R9 rx_enable", 32'(rx_enable), 32'(m_ctl[1]));
            check("R9 tx_start", 32'(tx_start), 32'(m_ctl[13]));
            check("R4 cur_rx", cur_rx_desc, m_crx);
            check("R4 cur_tx", cur_tx_desc, m_ctx);
        end
    end

    task automatic cyc(input bit w, input int idx, input logic [31:0] d,
                       input logic [31:0] ts, input logic [31:0] rs, input string tag);
        @(negedge clk); #1;
        csr_wr = w; csr_idx = 10'(idx); csr_wdata = d;
        tx_evt_set = ts; rx_evt_set = rs; rd_tag = tag;
    endtask

    task automatic wr(input int idx, input logic [31:0] d, input string tag);
        cyc(1, idx, d, 0, 0, tag);
    endtask

    task automatic rd(input int idx, input string tag);
        cyc(0, idx, 0, 0, 0, tag);
    endtask

    // Watchdog.
    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int lfsr = 32'h1ACE;
        int idxs [12] = '{'h3C0, 'h3C1, 'h3C3, 'h3C4, 'h3C5, 'h3C6,
                          'h3C7, 'h3D2, 'h3D3, 'h008, 'h3C2, 'h200};
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk_on = 1'b1;
        // R11 reset values
        rd('h3C0, "R11"); rd('h3C5, "R11"); rd('h3C7, "R11"); rd('h3D3, "R11");
        // R5 bus mode bit 0
        wr('h3C0, 32'hFFFF_FFFF, "R5"); rd('h3C0, "R5");
        // R9 control outputs
        wr('h3C6, 32'h0000_2002, "R9"); wr('h3C6, 32'h0000_0002, "R9");
        wr('h3C6, 32'h0000_2000, "R9"); rd('h3C6, "R1");
        // R4 ring base mirror and direct pointer writes
        wr('h3C3, 32'h0000_1000, "R4"); rd('h3D3, "R4");
        wr('h3D3, 32'h0000_1040, "R4"); rd('h3C3, "R4");
        wr('h3C4, 32'h0000_2000, "R4"); rd('h3D2, "R4");
        // R7 poll pulse, back to back, reads zero
        wr('h3C1, 32'hFFFF_FFFF, "R7"); rd('h3C1, "R7");
        wr('h3C1, 32'h1, "R7"); wr('h3C1, 32'h1, "R7"); rd('h3C1, "R7");
        // R6 version
        wr('h008, 32'hDEAD_BEEF, "R6"); rd('h008, "R6");
        // R10 unimplemented indices
        wr('h100, 32'h5555_5555, "R10"); rd('h100, "R10");
        wr('h3C2, 32'hAAAA_AAAA, "R10"); rd('h3C2, "R10"); rd('h3FF, "R10");
        // R3 engine sets, R8 interrupt masking
        cyc(0, 'h3C5, 0, 32'h1, 32'h40, "R3"); rd('h3C5, "R3");
        wr('h3C7, 32'h0000_0040, "R8"); rd('h3C5, "R8");
        // R2 write-one-to-clear
        wr('h3C5, 32'h0000_0001, "R2"); rd('h3C5, "R2");
        // R3 set beats clear on the same bit
        cyc(1, 'h3C5, 32'h0000_0040, 0, 32'h40, "R3"); rd('h3C5, "R3");
        wr('h3C5, 32'hFFFF_FFFF, "R2"); rd('h3C5, "R2");
        // Mixed traffic
        for (int i = 0; i < 120; i++) begin
            lfsr = (lfsr << 1) ^ (((lfsr >> 31) & 1) != 0 ? 32'h04C1_1DB7 : 0);
            cyc(lfsr[0], idxs[(lfsr >>> 4) & 32'h7FFF_FFFF % 12], lfsr,
                (lfsr[5:3] == 0) ? (32'h1 << lfsr[12:8]) : 0,
                (lfsr[7:6] == 0) ? (32'h1 << lfsr[20:16]) : 0, "R1");
        end
        rd('h3C5, "R3");
        @(negedge clk); #1;
        chk_on = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule